// File: doc/BRIEF.md
# Split-Mode Dual 8-bit Timer

This block is a timer/counter whose count register is cut into two independent 8-bit halves. The low half works as a full timer or event counter. It has a run bit, a gate qualifier driven by an external pin, and a source select that chooses between the machine-cycle tick and falling edges on an external count pin. The high half is a plain timer. It advances on every machine-cycle tick while its own run bit is set, and it owns the second overflow flag. Software therefore sees two separate 8-bit timers where there was one.

Each half wraps from 0xFF to 0x00 and raises its sticky overflow flag on that same clock edge. A flag stays set until its clear input or its interrupt-acknowledge input is pulsed. A write port can load either half. A load always beats a same-cycle increment and never raises a flag.

Top module: `split_timer`

## Requirements
- R1: In the cycle after a clock edge with `rst` high, both counts read 0x00 and both flags read 0.
- R2: With `ext_sel` = 0, the low count goes up by one at every clock edge where `tick` is 1 and the low half is enabled. With `tick` = 0 it holds.
- R3: When `gate_en` = 1, the low half is enabled only while `gate_pin` = 1. When `gate_en` = 0, `gate_pin` has no effect on the low count.
- R4: While `run_lo` = 0, the low count does not change except by a write.
- R5: With `ext_sel` = 1, `cnt_pin` is sampled only on `tick` cycles. The low count goes up by one on a tick whose sample is 0 when the previous tick's sample was 1. Pin changes between ticks do not count by themselves. The stored sample resets to 0.
- R6: The low count wraps from 0xFF to 0x00 and sets `ovf_lo` on the same edge. `ovf_hi` is unaffected.
- R7: The high count goes up by one at every `tick` edge while `run_hi` = 1. It ignores `ext_sel`, `gate_en`, `gate_pin`, `run_lo` and `cnt_pin`.
- R8: The high count wraps from 0xFF to 0x00 and sets `ovf_hi`, never `ovf_lo`.
- R9: Each flag stays set until its clear or acknowledge input is 1 at an edge. If a wrap and a clear fall on the same edge, the flag ends up set.
- R10: When `wr_en` = 1, `wr_data` is loaded into the low half (`wr_sel` = 0) or the high half (`wr_sel` = 1). The load wins over an increment on the same edge and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Machine-cycle strobe |
| cnt_pin | input | 1 | External event input for the low half |
| gate_pin | input | 1 | External gate level for the low half |
| run_lo | input | 1 | Run bit of the low half |
| run_hi | input | 1 | Run bit of the high half |
| gate_en | input | 1 | Low half also requires `gate_pin` high |
| ext_sel | input | 1 | Low half source: 0 tick, 1 pin falling edges |
| wr_en | input | 1 | Load strobe |
| wr_sel | input | 1 | Load target: 0 low, 1 high |
| wr_data | input | 8 | Load value |
| clr_lo | input | 1 | Clear low flag |
| clr_hi | input | 1 | Clear high flag |
| ack_lo | input | 1 | Interrupt acknowledge, low flag |
| ack_hi | input | 1 | Interrupt acknowledge, high flag |
| cnt_lo | output | 8 | Low half count |
| cnt_hi | output | 8 | High half count |
| ovf_lo | output | 1 | Low half overflow flag |
| ovf_hi | output | 1 | High half overflow flag |

## Verification
The hardest cases to reach are the collisions on a single edge: a wrap that meets a flag clear, and a write that meets an increment. Counting up to 0xFF from reset would take hundreds of cycles per attempt, so the stimulus preloads a half to 0xFF or 0xFE through the write port and then lines up the tick with the clear or the write on the chosen cycle. Counter mode gets a similar treatment. Pin transitions are placed both on tick cycles and between ticks, so a change that is never sampled is shown not to count.

// File: rtl/split_timer_pkg.sv
package split_timer_pkg;

    localparam int unsigned TMR_W   = 8;
    localparam int unsigned N_SLICE = 2;
    localparam int unsigned SL_LO   = 0;
    localparam int unsigned SL_HI   = 1;

    typedef logic [TMR_W-1:0] tmr_cnt_t;

    typedef enum logic {
        SRC_TICK = 1'b0,
        SRC_PIN  = 1'b1
    } clk_src_e;

    typedef struct packed {
        logic     inc;
        logic     load;
        tmr_cnt_t load_val;
        logic     flag_clr;
    } slice_ctl_t;

    function automatic logic at_top(input tmr_cnt_t v);
        return v == {TMR_W{1'b1}};
    endfunction

endpackage

// File: rtl/split_timer_fall_det.sv
module split_timer_fall_det (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic pin,
    output logic fall
);
    logic smp_q;

    always_ff @(posedge clk) begin
        if (rst)
            smp_q <= 1'b0;
        else if (tick)
            smp_q <= pin;
    end

    // a one-to-zero change seen between two consecutive tick samples
    assign fall = tick & smp_q & ~pin;
endmodule

// File: rtl/split_timer_slice.sv
module split_timer_slice
    import split_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  slice_ctl_t ctl,
    output tmr_cnt_t   cnt,
    output logic       flag
);
    tmr_cnt_t cnt_q;
    logic     flag_q;
    logic     wrap;

    assign wrap = ctl.inc & ~ctl.load & at_top(cnt_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (ctl.load)
                cnt_q <= ctl.load_val;
            else if (ctl.inc)
                cnt_q <= cnt_q + 1'b1;
            flag_q <= wrap | (flag_q & ~ctl.flag_clr);
        end
    end

    assign cnt  = cnt_q;
    assign flag = flag_q;
endmodule

// File: rtl/split_timer.sv
module split_timer
    import split_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             cnt_pin,
    input  logic             gate_pin,
    input  logic             run_lo,
    input  logic             run_hi,
    input  logic             gate_en,
    input  logic             ext_sel,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [TMR_W-1:0] wr_data,
    input  logic             clr_lo,
    input  logic             clr_hi,
    input  logic             ack_lo,
    input  logic             ack_hi,
    output logic [TMR_W-1:0] cnt_lo,
    output logic [TMR_W-1:0] cnt_hi,
    output logic             ovf_lo,
    output logic             ovf_hi
);
    logic       pin_fall;
    logic       lo_go;
    logic       lo_pulse;
    clk_src_e   lo_src;
    slice_ctl_t ctl [N_SLICE];
    tmr_cnt_t   cnt [N_SLICE];
    logic [N_SLICE-1:0] flg;

    split_timer_fall_det u_fall (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .pin  (cnt_pin),
        .fall (pin_fall)
    );

    assign lo_src   = ext_sel ? SRC_PIN : SRC_TICK;
    assign lo_go    = run_lo & (~gate_en | gate_pin);
    assign lo_pulse = (lo_src == SRC_PIN) ? pin_fall : tick;

    always_comb begin
        ctl[SL_LO].inc      = lo_go & lo_pulse;
        ctl[SL_LO].load     = wr_en & ~wr_sel;
        ctl[SL_LO].load_val = wr_data;
        ctl[SL_LO].flag_clr = clr_lo | ack_lo;

        ctl[SL_HI].inc      = run_hi & tick;
        ctl[SL_HI].load     = wr_en & wr_sel;
        ctl[SL_HI].load_val = wr_data;
        ctl[SL_HI].flag_clr = clr_hi | ack_hi;
    end

    for (genvar i = 0; i < N_SLICE; i++) begin : g_slice
        split_timer_slice u_slice (
            .clk  (clk),
            .rst  (rst),
            .ctl  (ctl[i]),
            .cnt  (cnt[i]),
            .flag (flg[i])
        );
    end

    assign cnt_lo = cnt[SL_LO];
    assign cnt_hi = cnt[SL_HI];
    assign ovf_lo = flg[SL_LO];
    assign ovf_hi = flg[SL_HI];
endmodule

// File: rtl/split_timer_chk.sv
module split_timer_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       run_lo,
    input logic       run_hi,
    input logic       gate_en,
    input logic       ext_sel,
    input logic       wr_en,
    input logic       wr_sel,
    input logic [7:0] wr_data,
    input logic       clr_lo,
    input logic       clr_hi,
    input logic       ack_lo,
    input logic       ack_hi,
    input logic [7:0] cnt_lo,
    input logic [7:0] cnt_hi,
    input logic       ovf_lo,
    input logic       ovf_hi
);
    // R4
    lo_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_lo && !wr_en) |=> $stable(cnt_lo));

    // R6
    lo_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && run_lo && !ext_sel && !gate_en && !wr_en && cnt_lo == 8'hFF)
        |=> (ovf_lo && cnt_lo == 8'h00));

    // R7
    hi_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && run_hi && !wr_en) |=> (cnt_hi == $past(cnt_hi) + 8'd1));

    // R8
    hi_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && run_hi && !wr_en && cnt_hi == 8'hFF) |=> (ovf_hi && cnt_hi == 8'h00));

    // R9
    lo_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_lo && !clr_lo && !ack_lo) |=> ovf_lo);

    // R9
    hi_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_hi && !clr_hi && !ack_hi) |=> ovf_hi);

    // R10
    hi_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel) |=> (cnt_hi == $past(wr_data) && !$rose(ovf_hi)));
endmodule

bind split_timer split_timer_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .run_lo  (run_lo),
    .run_hi  (run_hi),
    .gate_en (gate_en),
    .ext_sel (ext_sel),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .clr_lo  (clr_lo),
    .clr_hi  (clr_hi),
    .ack_lo  (ack_lo),
    .ack_hi  (ack_hi),
    .cnt_lo  (cnt_lo),
    .cnt_hi  (cnt_hi),
    .ovf_lo  (ovf_lo),
    .ovf_hi  (ovf_hi)
);

// File: tb/split_timer_tb.sv
module split_timer_tb;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, tick, cnt_pin, gate_pin, run_lo, run_hi, gate_en, ext_sel;
    logic wr_en, wr_sel, clr_lo, clr_hi, ack_lo, ack_hi;
    logic [7:0] wr_data, cnt_lo, cnt_hi;
    logic ovf_lo, ovf_hi;

    split_timer u_dut (
        .clk(clk), .rst(rst), .tick(tick), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
        .run_lo(run_lo), .run_hi(run_hi), .gate_en(gate_en), .ext_sel(ext_sel),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .clr_lo(clr_lo), .clr_hi(clr_hi), .ack_lo(ack_lo), .ack_hi(ack_hi),
        .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ovf_lo(ovf_lo), .ovf_hi(ovf_hi)
    );

    typedef struct {
        string      tag;
        logic [7:0] lo, hi;
        logic       flo, fhi;
    } exp_t;

    exp_t sbq[$];
    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // stimulus fields held between steps
    logic s_rst, s_tick, s_pin, s_gpin, s_rlo, s_rhi, s_gen, s_ext;
    logic s_we, s_ws, s_clo, s_chi, s_alo, s_ahi;
    logic [7:0] s_wd;

    // reference state built from the requirements
    logic [7:0] m_lo, m_hi;
    logic m_flo, m_fhi, m_smp;

    task automatic apply(input string tag);
        exp_t e;
        logic src, inc_lo, inc_hi, set_lo, set_hi;
        @(negedge clk);
        rst = s_rst; tick = s_tick; cnt_pin = s_pin; gate_pin = s_gpin;
        run_lo = s_rlo; run_hi = s_rhi; gate_en = s_gen; ext_sel = s_ext;
        wr_en = s_we; wr_sel = s_ws; wr_data = s_wd;
        clr_lo = s_clo; clr_hi = s_chi; ack_lo = s_alo; ack_hi = s_ahi;
        if (s_rst) begin
            m_lo = 0; m_hi = 0; m_flo = 0; m_fhi = 0; m_smp = 0;
        end else begin
            src    = s_ext ? (s_tick && m_smp && !s_pin) : s_tick;
            inc_lo = s_rlo && (!s_gen || s_gpin) && src;
            inc_hi = s_rhi && s_tick;
            if (s_tick) m_smp = s_pin;
            set_lo = 0; set_hi = 0;
            if (s_we && !s_ws) m_lo = s_wd;
            else if (inc_lo) begin set_lo = (m_lo == 8'hFF); m_lo = m_lo + 8'd1; end
            if (s_we && s_ws) m_hi = s_wd;
            else if (inc_hi) begin set_hi = (m_hi == 8'hFF); m_hi = m_hi + 8'd1; end
            m_flo = set_lo || (m_flo && !(s_clo || s_alo));
            m_fhi = set_hi || (m_fhi && !(s_chi || s_ahi));
        end
        e.tag = tag; e.lo = m_lo; e.hi = m_hi; e.flo = m_flo; e.fhi = m_fhi;
        sbq.push_back(e);
    endtask

    task automatic idle_inputs();
        s_rst = 0; s_tick = 0; s_pin = 0; s_gpin = 0; s_rlo = 0; s_rhi = 0;
        s_gen = 0; s_ext = 0; s_we = 0; s_ws = 0; s_wd = 0;
        s_clo = 0; s_chi = 0; s_alo = 0; s_ahi = 0;
    endtask

    task automatic load(input logic sel, input logic [7:0] v, input string tag);
        s_we = 1; s_ws = sel; s_wd = v;
        apply(tag);
        s_we = 0;
    endtask

    // monitor: compare one expected item a quarter period after each edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                n_vec++;
                if (cnt_lo !== e.lo || cnt_hi !== e.hi || ovf_lo !== e.flo || ovf_hi !== e.fhi) begin
                    n_bad++;
                    $display("FAIL %s: got lo=%h hi=%h flo=%b fhi=%b, expected lo=%h hi=%h flo=%b fhi=%b",
                             e.tag, cnt_lo, cnt_hi, ovf_lo, ovf_hi, e.lo, e.hi, e.flo, e.fhi);
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1; tick = 0; cnt_pin = 0; gate_pin = 0; run_lo = 0; run_hi = 0;
        gate_en = 0; ext_sel = 0; wr_en = 0; wr_sel = 0; wr_data = 0;
        clr_lo = 0; clr_hi = 0; ack_lo = 0; ack_hi = 0;
        m_lo = 0; m_hi = 0; m_flo = 0; m_fhi = 0; m_smp = 0;

        // R1 reset state
        s_rst = 1; s_tick = 1; s_rlo = 1; s_rhi = 1;
        apply("R1"); apply("R1");
        idle_inputs();
        apply("R1");

        // R2 timer mode, ticks interleaved with idle cycles
        s_rlo = 1;
        for (int i = 0; i < 12; i++) begin
            s_tick = (i % 3 != 1);
            apply("R2");
        end

        // R3 gate qualifier
        s_gen = 1; s_tick = 1;
        for (int i = 0; i < 8; i++) begin
            s_gpin = (i < 4) ? 1'b0 : 1'b1;
            apply("R3");
        end
        s_gen = 0;
        for (int i = 0; i < 4; i++) begin
            s_gpin = i[0];
            apply("R3");
        end

        // R4 run off, gate and pin wiggling
        s_rlo = 0;
        for (int i = 0; i < 6; i++) begin
            s_gpin = i[0]; s_pin = i[1];
            apply("R4");
        end

        // R10 + R6 load low near top and wrap
        load(1'b0, 8'hFD, "R10");
        s_rlo = 1; s_tick = 1;
        for (int i = 0; i < 5; i++) apply("R6");

        // R9 sticky, clear, acknowledge, clear colliding with a wrap
        s_rlo = 0;
        for (int i = 0; i < 3; i++) apply("R9");
        s_clo = 1; apply("R9"); s_clo = 0;
        apply("R9");
        load(1'b0, 8'hFF, "R10");
        s_rlo = 1; apply("R6"); s_rlo = 0;
        s_alo = 1; apply("R9"); s_alo = 0;
        apply("R9");
        load(1'b0, 8'hFF, "R10");
        s_rlo = 1; s_clo = 1; apply("R9"); s_clo = 0; s_rlo = 0;
        apply("R9"); apply("R9");
        s_clo = 1; apply("R9"); s_clo = 0;

        // R5 counter mode, transitions on and between ticks
        load(1'b0, 8'h40, "R10");
        s_ext = 1; s_rlo = 1;
        s_tick = 1; s_pin = 1; apply("R5");
        s_tick = 0; s_pin = 0; apply("R5");
        apply("R5");
        s_tick = 1; s_pin = 0; apply("R5");
        apply("R5");
        s_tick = 0; s_pin = 1; apply("R5");
        s_pin = 0; apply("R5");
        s_tick = 1; s_pin = 0; apply("R5");
        for (int i = 0; i < 10; i++) begin
            s_pin = i[0]; s_tick = 1;
            apply("R5");
        end

        // R7 high half alone, low half inputs varied
        s_rhi = 1;
        for (int i = 0; i < 10; i++) begin
            s_tick = (i != 3); s_ext = i[0]; s_gen = i[1]; s_gpin = i[2];
            s_rlo = i[0]; s_pin = i[1];
            apply("R7");
        end
        s_rlo = 0; s_ext = 0; s_gen = 0;

        // R8 high wrap, flag routing
        load(1'b1, 8'hFE, "R10");
        s_tick = 1;
        for (int i = 0; i < 4; i++) apply("R8");
        s_rhi = 0;
        s_ahi = 1; apply("R9"); s_ahi = 0;
        s_chi = 1; apply("R9"); s_chi = 0;

        // R10 write colliding with increments on both halves
        s_rlo = 1; s_rhi = 1; s_tick = 1;
        load(1'b0, 8'hFF, "R10");
        load(1'b1, 8'hFF, "R10");
        load(1'b0, 8'h10, "R10");
        apply("R10"); apply("R10");

        s_rst = 1; apply("R1");
        idle_inputs(); apply("R1");

        repeat (3) @(posedge clk);
        #7;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule